// File: doc/BRIEF.md
# Switch-Started 2x2 Matrix Multiplier with Scanned Display

This block holds two 2x2 operand matrices, A and B, which a processor loads through a simple register write port while the design runs. Software only loads operands. The multiplication itself starts from a board switch that the logic watches directly. That switch is synchronised and debounced, and its rising edge starts a clocked multiply-accumulate sequencer. The sequencer writes one entry of the result matrix Z on each clock.

The four Z entries can be read back on a combinational read port. They are also shown, one entry per digit, on a four-digit multiplexed seven-segment display while a second, debounced display switch is on. Every operand entry is 1 or 2, so each result entry lies between 2 and 8 and fits in four bits.

Top module: `mmd_top`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the operand selected by `wr_addr`. Addresses 0 to 3 hold a00, a01, a10 and a11, and addresses 4 to 7 hold b00, b01, b10 and b11. Operand values are 1 or 2. `rd_data` shows the Z entry selected by `rd_addr`, where 0 = z00, 1 = z01, 2 = z10 and 3 = z11. Every Z entry reads 0 after reset.
- R2: After a multiplication, each entry satisfies zij = ai0*b0j + ai1*b1j, held in registers.
- R3: The start switch passes two synchroniser flops and must then hold a new level for `DEB_CYCLES` consecutive clocks before the logic accepts it. A pulse shorter than that never starts a multiplication.
- R4: A rising edge of the debounced start level begins a four-cycle run that writes z00, z01, z10 and z11 in that order, one per clock. `done` is high for exactly one clock when the last entry is written. A start pulse that arrives while a run is in progress is ignored.
- R5: Writing new operands leaves Z, both on `rd_data` and on the display, unchanged until the next start.
- R6: Only one anode is driven at a time; `an_n` is active-low. Digit 3 shows z00, digit 2 shows z01, digit 1 shows z10 and digit 0 shows z11. Each digit is held for `SCAN_CYCLES` clocks, and the scan visits all four digits.
- R7: `seg_n[0]` to `seg_n[6]` drive segments a to g, active-low. Lit segments, given as the hex value of the g..a bits, are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. `dp_n` always stays high, so the decimal point is never lit.
- R8: All anodes stay high (blank) while the debounced display switch is off, and also before the first multiplication has completed.
- R9: Holding the start switch on produces only one multiplication, and turning it off starts none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Operand write strobe |
| wr_addr | input | 3 | Operand select (0-3 A, 4-7 B, row-major) |
| wr_data | input | ENTRY_W | Operand value (1 or 2) |
| rd_addr | input | 2 | Result entry select, row-major |
| rd_data | output | RES_W | Selected result entry |
| sw_go | input | 1 | Raw start switch |
| sw_show | input | 1 | Raw display switch |
| done | output | 1 | One-clock pulse when the result is complete |
| an_n | output | 4 | Digit anodes, active-low |
| seg_n | output | 7 | Segments a..g, active-low |
| dp_n | output | 1 | Decimal point, active-low (held off) |

## Verification
The assertions assume that every operand written has the value 1 or 2. Under that assumption, a result above 8 can only come from a fault. They also take for granted that the raw switches change slowly compared with the four-cycle run, so starts never overlap.

The stimulus writes only 1 or 2, sweeping all 256 combinations of the eight operands. It leaves the start switch steady for well over the debounce window between runs, except in deliberate short glitches that test the filter.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    localparam int NUM_ENTRIES = 4;

    // Seven-segment glyph, bit 0 = a ... bit 6 = g, active-high.
    function automatic logic [6:0] glyph_on(input logic [3:0] v);
        logic [6:0] g;
        case (v)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/mmd_switch_cond.sv
module mmd_switch_cond #(
    parameter int DEB_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          level;
    } cond_t;

    cond_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sync = {st_q.sync[0], raw_i};
        if (st_q.sync[1] == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(DEB_CYCLES - 1)) begin
            st_d.cnt   = '0;
            st_d.level = st_q.sync[1];
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;

    AST_LEVEL_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level != $past(st_q.level)) |-> (st_q.level == $past(st_q.sync[1]))); // R3

endmodule

// File: rtl/mmd_mac_seq.sv
module mmd_mac_seq #(
    parameter int ENTRY_W = 2,
    parameter int RES_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            wr_addr,
    input  logic [ENTRY_W-1:0]    wr_data,
    input  logic                  start_i,
    output logic [3:0][RES_W-1:0] z_o,
    output logic                  valid_o,
    output logic                  done_o
);
    localparam int SUM_W = 2 * ENTRY_W + 1;

    typedef struct packed {
        logic [3:0][ENTRY_W-1:0] a;
        logic [3:0][ENTRY_W-1:0] b;
        logic [3:0][RES_W-1:0]   z;
        logic [1:0]              idx;
        logic                    busy;
        logic                    done;
        logic                    valid;
    } seq_t;

    seq_t st_d, st_q;
    logic [SUM_W-1:0] sum;
    logic             row, col;

    always_comb begin
        row = st_q.idx[1];
        col = st_q.idx[0];
        sum = SUM_W'(st_q.a[{row, 1'b0}]) * SUM_W'(st_q.b[{1'b0, col}])
            + SUM_W'(st_q.a[{row, 1'b1}]) * SUM_W'(st_q.b[{1'b1, col}]);

        st_d      = st_q;
        st_d.done = 1'b0;
        if (wr_en) begin
            if (wr_addr[2]) st_d.b[wr_addr[1:0]] = wr_data;
            else            st_d.a[wr_addr[1:0]] = wr_data;
        end
        if (st_q.busy) begin
            st_d.z[st_q.idx] = RES_W'(sum);
            st_d.idx         = st_q.idx + 2'd1;
            if (st_q.idx == 2'd3) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.valid = 1'b1;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.idx  = 2'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign z_o     = st_q.z;
    assign valid_o = st_q.valid;
    assign done_o  = st_q.done;

    AST_OPERAND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data == ENTRY_W'(1) || wr_data == ENTRY_W'(2))); // R1
    AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.z[0] <= RES_W'(8) && st_q.z[1] <= RES_W'(8)
                    && st_q.z[2] <= RES_W'(8) && st_q.z[3] <= RES_W'(8))); // R2
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> ($past(st_q.busy) && $past(st_q.idx) == 2'd3 && !st_q.busy)); // R4
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.idx != 2'd3) |=> (st_q.busy && st_q.idx == $past(st_q.idx) + 2'd1)); // R4
    AST_Z_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !$past(st_q.busy)) |-> $stable(st_q.z)); // R5

endmodule

// File: rtl/mmd_scan.sv
module mmd_scan #(
    parameter int RES_W       = 4,
    parameter int SCAN_CYCLES = 50000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  show_i,
    input  logic                  valid_i,
    input  logic [3:0][RES_W-1:0] z_i,
    output logic [3:0]            an_n,
    output logic [6:0]            seg_n,
    output logic                  dp_n
);
    localparam int CW = $clog2(SCAN_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    dig;
    } scan_t;

    scan_t st_d, st_q;
    logic [RES_W-1:0] cur;
    logic             lit;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CW'(SCAN_CYCLES - 1)) begin
            st_d.cnt = '0;
            st_d.dig = st_q.dig + 2'd1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        lit = show_i && valid_i;
        cur = z_i[2'd3 - st_q.dig];
        if (lit) begin
            an_n  = ~(4'b0001 << st_q.dig);
            seg_n = ~mmd_pkg::glyph_on(4'(cur));
        end else begin
            an_n  = 4'hF;
            seg_n = 7'h7F;
        end
        dp_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~an_n)); // R6
    AST_DIGIT_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> $stable(st_q.dig)); // R6
    AST_BLANK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(show_i && valid_i) |-> (an_n == 4'hF)); // R8

endmodule

// File: rtl/mmd_top.sv
module mmd_top #(
    parameter int ENTRY_W     = 2,
    parameter int RES_W       = 4,
    parameter int DEB_CYCLES  = 500000,
    parameter int SCAN_CYCLES = 50000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [1:0]         rd_addr,
    output logic [RES_W-1:0]   rd_data,
    input  logic               sw_go,
    input  logic               sw_show,
    output logic               done,
    output logic [3:0]         an_n,
    output logic [6:0]         seg_n,
    output logic               dp_n
);
    logic                  go_lvl, show_lvl, valid;
    logic                  go_prev_d, go_prev_q, start;
    logic [3:0][RES_W-1:0] z;

    mmd_switch_cond #(.DEB_CYCLES(DEB_CYCLES)) u_go (
        .clk(clk), .rst_n(rst_n), .raw_i(sw_go), .level_o(go_lvl));

    mmd_switch_cond #(.DEB_CYCLES(DEB_CYCLES)) u_show (
        .clk(clk), .rst_n(rst_n), .raw_i(sw_show), .level_o(show_lvl));

    always_comb begin
        go_prev_d = go_lvl;
        start     = go_lvl && !go_prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) go_prev_q <= 1'b0;
        else        go_prev_q <= go_prev_d;
    end

    mmd_mac_seq #(.ENTRY_W(ENTRY_W), .RES_W(RES_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start_i(start), .z_o(z), .valid_o(valid),
        .done_o(done));

    mmd_scan #(.RES_W(RES_W), .SCAN_CYCLES(SCAN_CYCLES)) u_scan (
        .clk(clk), .rst_n(rst_n), .show_i(show_lvl), .valid_i(valid),
        .z_i(z), .an_n(an_n), .seg_n(seg_n), .dp_n(dp_n));

    assign rd_data = z[rd_addr];

    AST_START_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start); // R9

endmodule

// File: tb/sim_mmd_top.sv
module sim_mmd_top;
    localparam int EW = 2, RW = 4, DEB = 4, SCAN = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, sw_go = 1'b0, sw_show = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [EW-1:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [RW-1:0] rd_data;
    logic done, dp_n;
    logic [3:0] an_n;
    logic [6:0] seg_n;

    int errors = 0, checks = 0, done_cnt = 0;
    int a[4], b[4], ez[4];

    always #10 clk = ~clk;

    mmd_top #(.ENTRY_W(EW), .RES_W(RW), .DEB_CYCLES(DEB), .SCAN_CYCLES(SCAN)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sw_go(sw_go), .sw_show(sw_show), .done(done), .an_n(an_n),
        .seg_n(seg_n), .dp_n(dp_n));

    always @(negedge clk) if (rst_n && done) done_cnt++;

    function automatic logic [6:0] want_seg(input int v);
        logic [6:0] g;
        case (v)
            0: g = 7'h3F; 1: g = 7'h06; 2: g = 7'h5B; 3: g = 7'h4F;
            4: g = 7'h66; 5: g = 7'h6D; 6: g = 7'h7D; 7: g = 7'h07;
            8: g = 7'h7F; default: g = 7'h6F;
        endcase
        return ~g;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = EW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int c);
        for (int i = 0; i < 4; i++) begin
            a[i] = 1 + ((c >> i) & 1);
            b[i] = 1 + ((c >> (4 + i)) & 1);
            wr(i, a[i]);
            wr(4 + i, b[i]);
        end
    endtask

    task automatic read_check(input string req, input int e[4]);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd_addr = 2'(i);
            #1;
            check(req, int'(rd_data), e[i]);
        end
    endtask

    task automatic run_start();
        sw_go = 1'b0;
        repeat (DEB + 6) @(negedge clk);
        sw_go = 1'b1;
        repeat (DEB + 14) @(negedge clk);
    endtask

    task automatic check_display(input int e[4]);
        logic [3:0] seen = '0;
        for (int k = 0; k < 8 * SCAN; k++) begin
            @(negedge clk);
            check("R7 dp", int'(dp_n), 1);
            check("R6 onehot", int'($countones(~an_n) <= 1), 1);
            for (int d = 0; d < 4; d++) begin
                if (an_n == ~(4'b0001 << d)) begin
                    seen[d] = 1'b1;
                    check("R7 seg", int'(seg_n), int'(want_seg(e[3 - d])));
                end
            end
        end
        check("R6 all digits", int'(seen), 15);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int prev[4];
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        prev = '{0, 0, 0, 0};
        read_check("R1 reset", prev);
        // R8 blank before any result even with the display switch on
        sw_show = 1'b1;
        repeat (DEB + 8) @(negedge clk);
        check("R8 blank before result", int'(an_n), 15);

        for (int c = 0; c < 256; c++) begin
            load(c);
            for (int r = 0; r < 2; r++)
                for (int q = 0; q < 2; q++)
                    ez[r * 2 + q] = a[r * 2] * b[q] + a[r * 2 + 1] * b[2 + q];
            if (c > 0) read_check("R5 operands not applied", prev);
            d0 = done_cnt;
            run_start();
            check("R4 one done per start", done_cnt - d0, 1);
            read_check("R2 product", ez);
            if (c % 37 == 0) check_display(ez);
            prev = ez;
        end

        // R9: holding on gives no extra run, switching off starts nothing
        d0 = done_cnt;
        repeat (40) @(negedge clk);
        sw_go = 1'b0;
        repeat (DEB + 20) @(negedge clk);
        check("R9 hold and release", done_cnt - d0, 0);

        // R3: glitches shorter than the debounce window are rejected
        load(0);
        for (int g = 0; g < 5; g++) begin
            sw_go = 1'b1;
            repeat (DEB - 2) @(negedge clk);
            sw_go = 1'b0;
            repeat (DEB + 4) @(negedge clk);
        end
        check("R3 glitch no done", done_cnt - d0, 0);
        read_check("R3 glitch z held", prev);
        check_display(prev);

        // R8: display switch off blanks the digits
        sw_show = 1'b0;
        repeat (DEB + 8) @(negedge clk);
        for (int k = 0; k < 4 * SCAN; k++) begin
            @(negedge clk);
            check("R8 blank when off", int'(an_n), 15);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule